// File: doc/BRIEF.md
# Register-Exchange Survivor Path Unit

This block holds the survivor path of every trellis state of a hard-decision convolutional decoder with memory MEM (256 states by default). A path metric unit, outside this block, delivers one beat per received symbol: a decision vector with one bit per state, which says which of the two predecessors won, and the index of the state that currently has the smallest metric. Each state owns a DEPTH-bit shift register. On every accepted beat, each register is rebuilt by copying the register of the chosen predecessor, moving it one place toward the oldest end, and appending the state's own newest input bit.

No traceback pass is needed. Once DEPTH beats have been accepted, every further beat yields one decoded bit: the oldest bit of the survivor that belongs to the best state. The latency is fixed at DEPTH beats.

Both sides are valid/ready streams. An input beat is taken when `in_valid` and `in_ready` are both high. An output bit is consumed when `out_valid` and `out_ready` are both high. `in_ready` is high when no output is pending, or when the pending output is being consumed in the same cycle. While an output waits with `out_ready` low, no input is taken and the output holds its value.

Top module: `sx_survivor_xchg`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` stays 0 until DEPTH beats have been accepted since reset. It first rises in the cycle after the DEPTH-th accepted beat. Idle cycles during the fill do not count.
- R3: From the DEPTH-th accepted beat onward, each accepted beat produces exactly one output bit. The bit produced by accepted beat n (counted from 1) is the decoded bit of input symbol n-DEPTH (counted from 0).
- R4: A state index holds the last MEM input bits, with the newest bit in the MSB. For state s, decision bit `in_decision[s]` = d selects predecessor ((s << 1) | d) mod 2^MEM. The new register of s is that predecessor's register moved one place toward the oldest end, with the MSB of s as the newest bit.
- R5: `out_bit` is the oldest bit of the register of the state given on `in_best` with the same beat. For example, when every decision equals its state's MSB, `out_bit` equals bit ((MEM-1-(DEPTH-1)) mod MEM) of that best index.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and both `out_valid` and `out_bit` hold.
- R7: A cycle with no accepted beat and no consumed output changes neither `out_valid` nor `out_bit`.
- R8: Fed by a hard-decision metric unit for the rate-1/2 code with octal generators 561 and 753, the output equals the transmitted data. This holds also with a burst of up to 5 flipped code bits, including the first 5 code bits of a frame. Window bit 8 is the current input and bits 7..0 are the state; the first generator gives the first transmitted bit.
- R9: A consumed output with no accepted beat in the same cycle makes `out_valid` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decision beat offered |
| in_ready | output | 1 | Decision beat can be taken |
| in_decision | input | 2^MEM | Per-state predecessor choice |
| in_best | input | MEM | Index of the minimum-metric state for this beat |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Downstream takes the decoded bit |
| out_bit | output | 1 | Decoded bit |

## Verification
A wrong predecessor link or a wrong appended bit corrupts the survivors, but the damage reaches `out_bit` only once it has travelled to the oldest position. It therefore shows up about DEPTH accepted beats later, as mismatches against the delayed data. The rotation pattern exposes it deterministically. An off-by-one in the fill count shows at once: `out_valid` rises one beat early or late, and every later bit is misaligned against the data. A stale or misrouted best index shows in the very next output bit under the rotation pattern. Handshake faults show within one cycle as a lost, repeated or changed held bit.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic {PH_FILL, PH_RUN} phase_e;

  // Predecessor of state s when its decision bit is d (newest bit in MSB).
  function automatic int unsigned pred_state(int unsigned s, int unsigned d,
                                             int unsigned mem);
    return ((s << 1) | (d & 1)) & ((1 << mem) - 1);
  endfunction

endpackage

// File: rtl/sx_fill_ctrl.sv
module sx_fill_ctrl
  import sx_pkg::*;
#(
  parameter int DEPTH = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic advance
);
  localparam int CW = $clog2(DEPTH + 1);

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic            valid_q;
  logic            last_fill;

  assign in_ready  = !valid_q || out_ready;
  assign advance   = in_valid && in_ready;
  assign out_valid = valid_q;
  assign last_fill = (cnt_q == CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (advance) begin
      if (phase_q == PH_FILL) begin
        if (last_fill) begin
          phase_q <= PH_RUN;
          valid_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q + CW'(1);
        end
      end else begin
        valid_q <= 1'b1;
      end
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sx_path_array.sv
module sx_path_array
  import sx_pkg::*;
#(
  parameter int MEM   = 8,
  parameter int DEPTH = 45,
  localparam int NS   = 1 << MEM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [NS-1:0] dec,
  output logic [NS-1:0] oldest
);
  logic [DEPTH-1:0] path_w [NS];

  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int unsigned P0 = pred_state(s, 0, MEM);
    localparam int unsigned P1 = pred_state(s, 1, MEM);
    localparam logic NEWBIT = 1'(s >> (MEM - 1));

    logic [DEPTH-1:0] path_q;
    logic [DEPTH-2:0] parent;

    assign parent = dec[s] ? path_w[P1][DEPTH-2:0] : path_w[P0][DEPTH-2:0];

    always_ff @(posedge clk) begin
      if (!rst_n)       path_q <= '0;
      else if (advance) path_q <= {parent, NEWBIT};
    end

    assign path_w[s] = path_q;
    assign oldest[s] = path_w[s][DEPTH-1];
  end
endmodule

// File: rtl/sx_out_select.sv
module sx_out_select #(
  parameter int MEM = 8,
  localparam int NS = 1 << MEM
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic [MEM-1:0] best,
  input  logic [NS-1:0]  oldest,
  output logic           out_bit
);
  logic [MEM-1:0] best_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       best_q <= '0;
    else if (advance) best_q <= best;
  end

  assign out_bit = oldest[best_q];
endmodule

// File: rtl/sx_survivor_xchg.sv
module sx_survivor_xchg #(
  parameter int MEM   = 8,
  parameter int DEPTH = 45
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [(1<<MEM)-1:0]   in_decision,
  input  logic [MEM-1:0]        in_best,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_bit
);
  localparam int NS = 1 << MEM;

  logic          advance;
  logic [NS-1:0] oldest;

  sx_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .advance(advance)
  );

  sx_path_array #(.MEM(MEM), .DEPTH(DEPTH)) u_paths (
    .clk(clk), .rst_n(rst_n), .advance(advance), .dec(in_decision),
    .oldest(oldest)
  );

  sx_out_select #(.MEM(MEM)) u_sel (
    .clk(clk), .rst_n(rst_n), .advance(advance), .best(in_best),
    .oldest(oldest), .out_bit(out_bit)
  );
endmodule

// File: rtl/sx_survivor_xchg_chk.sv
module sx_survivor_xchg_chk #(
  parameter int MEM   = 8,
  parameter int DEPTH = 45
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          take;
  logic          give;
  logic [CW-1:0] acc_q;

  assign take = in_valid && in_ready;
  assign give = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                          acc_q <= '0;
    else if (take && acc_q != CW'(DEPTH)) acc_q <= acc_q + CW'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);

  assert_fill_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_q == CW'(DEPTH));

  assert_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_q >= CW'(DEPTH - 1) |=> out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !give |=> $stable(out_valid) && $stable(out_bit));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    give && !take |=> !out_valid);
endmodule

bind sx_survivor_xchg sx_survivor_xchg_chk #(.MEM(MEM), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
);

// File: tb/test_sx_survivor_xchg.sv
`timescale 1ns/1ps
module test_sx_survivor_xchg;
  localparam int MEM   = 8;
  localparam int NS    = 1 << MEM;
  localparam int DEPTH = 45;
  localparam int DLEN  = 64;
  localparam int TAIL  = 8;
  localparam int NSYM  = DLEN + TAIL + DEPTH - 1;
  localparam int NOUT  = NSYM - DEPTH + 1;
  localparam int NCASE = 6;
  // {mode[23:20], burst_len[19:16], burst_start[15:8], seed[7:0]}
  // mode 0 lfsr, 1 single one then zeros, 2 all ones, 3 alternating
  localparam logic [23:0] CASES [NCASE] = '{
    24'h00_005A, 24'h15_0001, 24'h05_28C3,
    24'h24_4D01, 24'h33_0A01, 24'h05_6417
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b1;
  logic [NS-1:0] in_decision = '0;
  logic [MEM-1:0] in_best = '0;
  logic          in_ready, out_valid, out_bit;
  int            total = 0, bad = 0;
  bit            done = 1'b0;
  int            pm [NS];

  always #4 clk = ~clk;

  sx_survivor_xchg #(.MEM(MEM), .DEPTH(DEPTH)) i_sx_survivor_xchg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decision(in_decision), .in_best(in_best), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input logic [7:0] st, input logic u);
    logic [8:0] w;
    w = {u, st};
    return {^(w & 9'o561), ^(w & 9'o753)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acs(input logic [1:0] rx);
    int npm [NS];
    int mn;
    mn = 1 << 30;
    for (int s = 0; s < NS; s++) begin
      logic [7:0] n8, p0, p1;
      int m0, m1;
      n8 = 8'(s);
      p0 = {n8[6:0], 1'b0};
      p1 = {n8[6:0], 1'b1};
      m0 = pm[p0] + $countones(enc(p0, n8[7]) ^ rx);
      m1 = pm[p1] + $countones(enc(p1, n8[7]) ^ rx);
      in_decision[s] = (m1 < m0);
      npm[s] = (m1 < m0) ? m1 : m0;
      if (npm[s] < mn) begin mn = npm[s]; in_best = n8; end
    end
    for (int s = 0; s < NS; s++) pm[s] = npm[s] - mn;
  endtask

  task automatic run_case(input logic [23:0] c);
    logic u [NSYM];
    logic [7:0] lf, est;
    logic [1:0] sym;
    int first, nout, mism, bst, blen;
    bst = int'(c[15:8]); blen = int'(c[19:16]); lf = c[7:0];
    for (int i = 0; i < NSYM; i++) begin
      if (i >= DLEN) u[i] = 1'b0;
      else case (c[23:20])
        4'd0: begin u[i] = lf[0]; lf = {lf[0]^lf[2]^lf[3]^lf[4], lf[7:1]}; end
        4'd1: u[i] = (i == 0);
        4'd2: u[i] = 1'b1;
        default: u[i] = (i % 2 == 0);
      endcase
    end
    do_reset();
    for (int s = 0; s < NS; s++) pm[s] = (s == 0) ? 0 : 1000;
    est = '0; first = -1; nout = 0; mism = 0;
    for (int i = 0; i < NSYM; i++) begin
      sym = enc(est, u[i]);
      est = {u[i], est[7:1]};
      if (2*i >= bst && 2*i < bst + blen) sym[1] = ~sym[1];
      if (2*i+1 >= bst && 2*i+1 < bst + blen) sym[0] = ~sym[0];
      acs(sym);
      in_valid = 1'b1;
      @(negedge clk);
      if (out_valid) begin
        if (first < 0) first = i + 1;
        if (nout < NOUT && out_bit !== u[nout]) mism++;
        nout++;
      end
    end
    in_valid = 1'b0;
    check(first == DEPTH, "R2 first output after DEPTH beats", first, DEPTH);
    check(nout == NOUT, "R3 one bit per beat", nout, NOUT);
    check(mism == 0, "R8/R4 decoded bits match data", mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] rot;
    logic [MEM-1:0] bests [4];
    logic held;
    int idx;
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    for (int k = 0; k < NCASE; k++) run_case(CASES[k]);

    // R5/R4: rotation decisions make the output a fixed bit of the best index
    for (int s = 0; s < NS; s++) rot[s] = 1'(s >> (MEM - 1));
    idx = ((MEM - 1 - (DEPTH - 1)) % MEM + MEM) % MEM;
    bests = '{8'h08, 8'hF7, 8'h80, 8'h0F};
    do_reset();
    in_decision = rot; in_best = '0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      in_valid = 1'b1; @(negedge clk);
    end
    // R7: idle cycles during the fill are not counted
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 idle during fill", int'(out_valid), 0);
    in_valid = 1'b1; @(negedge clk);
    check(out_valid == 1'b1, "R2 valid after DEPTH-th beat", int'(out_valid), 1);
    check(out_bit == 1'b0, "R5 best 0", int'(out_bit), 0);
    for (int k = 0; k < 4; k++) begin
      in_best = bests[k]; @(negedge clk);
      check(out_bit == bests[k][idx], "R5 oldest bit of best state",
            int'(out_bit), int'(bests[k][idx]));
    end
    // R6: stall holds output and blocks input
    held = out_bit;
    out_ready = 1'b0; in_best = ~in_best;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R6 in_ready low while stalled", int'(in_ready), 0);
    check(out_valid == 1'b1 && out_bit == held, "R6 output held",
          int'(out_bit), int'(held));
    // R7: idle with output pending changes nothing
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b1 && out_bit == held, "R7 idle keeps output",
          int'(out_bit), int'(held));
    // R9: drain
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid clears after consume", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after drain", int'(in_ready), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule